// File: doc/BRIEF.md
# Interrupt Entry and Opcode Override Unit

This unit is the interrupt-service front end of an 8-bit processor core. It holds the two interrupt enable flags, the interrupt mode and three service states: halted, maskable-interrupt service and non-maskable service. While a service state is active, it replaces the byte taken from the bus during opcode fetch with a substitute. Halt substitutes a no-operation. Maskable service in modes 1 and 2, and non-maskable service, substitute the all-ones restart opcode. The rest of the core then executes the substitute like any fetched instruction.

The unit also forms the low byte of the restart target and tells the program counter to stay put while a service state is active. In maskable mode 2 it asks for one extra memory read, which fetches the vector table entry. The instruction decoder drives strobes into the unit. It marks each opcode-load step and each instruction boundary. It also reports halt, return-from-NMI, enable/disable and mode-set instructions, together with opcode bits [4:3] of the current instruction.

Requests are accepted only at instruction boundaries. A non-maskable request is caught on its rising edge and held until it is serviced, and it wins over a maskable request.

Top module: `irq_entry_unit`

## Requirements
- R1: Reset (rstN low) clears iff1, iff2 and intMode to 0 and leaves inHalt, inIntr, inNmi and pcHold at 0. With no service state active, opcodeOut equals fetchByte.
- R2: While inHalt is 1, opcodeOut is 0x00 whatever fetchByte holds.
- R3: While inNmi is 1, or inIntr is 1 with intMode 2'b01 or 2'b10, opcodeOut is 0xFF. When inIntr is 1 with intMode 2'b00, fetchByte passes through unchanged.
- R4: vectorByte is 0x66 while inNmi is 1, and 0x00 while inIntr is 1 with intMode 2'b10. Otherwise vectorByte is opcodeOut bits [5:3] placed at bits [5:3], with all other bits 0.
- R5: pcHold is 1 exactly when inHalt, inIntr or inNmi is 1.
- R6: A rising edge on nmiReq is latched. At the next unblocked boundary, inNmi rises and inIntr stays 0, even if intReq is asserted with iff1 = 1. One cycle after inNmi rises, iff1 is 0 and iff2 keeps its value. The latch is consumed by the service, so a level held on nmiReq does not trigger it again.
- R7: At a boundary, intReq is accepted (inIntr rises) only when iff1 is 1, no non-maskable request is latched and the boundary is not blocked. One cycle after inIntr rises, both iff1 and iff2 are 0.
- R8: If opLoad sees an opcodeOut of 0xF3, 0xFB, 0xCB, 0xED, 0xDD or 0xFD, the next boundary accepts neither request. The boundary after that accepts them normally.
- R9: diEiStrobe loads opField[0] (opcode bit 3) into both iff1 and iff2: 0 disables, 1 enables. retnStrobe copies iff2 into iff1.
- R10: imStrobe sets intMode from opField (opcode bits [4:3]). The value 2'b10 gives mode 1 (2'b01), 2'b11 gives mode 2 (2'b10), and 2'b00 or 2'b01 gives mode 0 (2'b00).
- R11: extraRead is 1 exactly while inIntr is 1 and intMode is 2'b10.
- R12: haltOp sets inHalt. Accepting either request clears inHalt. inIntr and inNmi last until the next boundary that accepts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchByte | input | 8 | Byte read from the bus during opcode fetch |
| opField | input | 2 | Bits [4:3] of the current instruction, used by the strobes |
| opLoad | input | 1 | Opcode-load step of the fetch cycle |
| boundary | input | 1 | Instruction boundary, where requests are sampled |
| haltOp | input | 1 | A halt instruction has executed |
| retnStrobe | input | 1 | Return-from-NMI instruction |
| diEiStrobe | input | 1 | Enable or disable interrupts instruction |
| imStrobe | input | 1 | Set interrupt mode instruction |
| nmiReq | input | 1 | Raw non-maskable request, edge sensitive |
| intReq | input | 1 | Raw maskable request, level sensitive |
| opcodeOut | output | 8 | Effective opcode for the instruction register |
| vectorByte | output | 8 | Low byte of the restart target |
| pcHold | output | 1 | Suppress the program counter increment |
| iff1 | output | 1 | Interrupt enable flag 1 |
| iff2 | output | 1 | Interrupt enable flag 2 |
| intMode | output | 2 | Current interrupt mode |
| inHalt | output | 1 | Halt state |
| inIntr | output | 1 | Maskable service state |
| inNmi | output | 1 | Non-maskable service state |
| extraRead | output | 1 | Request for the extra vector read in mode 2 |

## Verification
The bench asserts a non-maskable edge and a maskable request together, to catch a design that lets the maskable request win or reclears iff2. It checks that the enable flags still hold their old values in the cycle the service state rises, and that they drop one cycle later. A design that clears them combinationally, or never clears them, fails here. A blocking opcode is followed by a request that must wait exactly one boundary, which catches a design that ignores the block or never releases it. The bench also drives the two unusual mode codes, the mode-0 pass-through and a halt exit, to catch a design with a wrong mode mapping or an unconditional override.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  // Service states shared from control to datapath
  typedef struct packed {
    logic halt;
    logic intr;
    logic nmi;
  } svc_t;

  localparam logic [1:0] MODE0 = 2'b00;
  localparam logic [1:0] MODE1 = 2'b01;
  localparam logic [1:0] MODE2 = 2'b10;

  // Opcode bits [4:3] of the mode-set instruction to mode code
  function automatic logic [1:0] modeFromField(input logic [1:0] f);
    case (f)
      2'b10:   return MODE1;
      2'b11:   return MODE2;
      default: return MODE0;
    endcase
  endfunction
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opLoad,
  input  logic            boundary,
  input  logic            haltOp,
  input  logic            nmiReq,
  input  logic            intReq,
  input  logic            iff1,
  input  logic [OP_W-1:0] opcodeOut,
  output svc_t            svc
);
  localparam logic [OP_W-1:0] DI_CODE  = OP_W'(8'hF3);
  localparam logic [OP_W-1:0] EI_CODE  = OP_W'(8'hFB);
  localparam logic [OP_W-1:0] PFX_BIT  = OP_W'(8'hCB);
  localparam logic [OP_W-1:0] PFX_EXT  = OP_W'(8'hED);
  localparam logic [OP_W-1:0] PFX_IDXA = OP_W'(8'hDD);
  localparam logic [OP_W-1:0] PFX_IDXB = OP_W'(8'hFD);

  logic nmiSeen, nmiPend, blockNext;
  logic haltQ, intrQ, nmiQ;
  logic nmiRise, takeNmi, takeInt, isBlocker;

  assign nmiRise = nmiReq & ~nmiSeen;
  assign takeNmi = boundary & nmiPend & ~blockNext;
  assign takeInt = boundary & intReq & iff1 & ~nmiPend & ~blockNext;

  always_comb begin
    isBlocker = 1'b0;
    if (opcodeOut == DI_CODE || opcodeOut == EI_CODE ||
        opcodeOut == PFX_BIT || opcodeOut == PFX_EXT ||
        opcodeOut == PFX_IDXA || opcodeOut == PFX_IDXB)
      isBlocker = 1'b1;
  end

  // Non-maskable edge catcher
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiSeen <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiSeen <= nmiReq;
      nmiPend <= nmiRise | (nmiPend & ~takeNmi);
    end
  end

  // One-boundary acceptance block after enable/disable and prefixes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         blockNext <= 1'b0;
    else if (opLoad)   blockNext <= isBlocker;
    else if (boundary) blockNext <= 1'b0;
  end

  // Service states
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ <= 1'b0;
      intrQ <= 1'b0;
      nmiQ  <= 1'b0;
    end else begin
      if (boundary) begin
        nmiQ  <= takeNmi;
        intrQ <= takeInt;
      end
      haltQ <= (takeNmi | takeInt) ? 1'b0 : (haltQ | haltOp);
    end
  end

  assign svc.halt = haltQ;
  assign svc.intr = intrQ;
  assign svc.nmi  = nmiQ;

  // R7
  int_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intrQ) |-> ($past(iff1) && !$past(blockNext) && !$past(nmiPend)));

  // R6
  svc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({intrQ, nmiQ}));

  // R8
  nmi_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiQ) |-> !$past(blockNext));
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int              OP_W     = 8,
  parameter logic [OP_W-1:0] NOP_CODE = '0,
  parameter logic [OP_W-1:0] RST_CODE = '1,
  parameter logic [OP_W-1:0] NMI_VEC  = OP_W'(8'h66)
) (
  input  logic            clk,
  input  logic            rstN,
  input  svc_t            svc,
  input  logic [OP_W-1:0] fetchByte,
  input  logic [1:0]      opField,
  input  logic            retnStrobe,
  input  logic            diEiStrobe,
  input  logic            imStrobe,
  output logic [OP_W-1:0] opcodeOut,
  output logic [OP_W-1:0] vectorByte,
  output logic            pcHold,
  output logic            iff1,
  output logic            iff2,
  output logic [1:0]      intMode,
  output logic            extraRead
);
  localparam int RST_LO = 3;
  localparam int RST_HI = 5;

  logic prevIntr, prevNmi;
  logic intrEntry, nmiEntry;
  logic fastMode, vecMasked;

  assign intrEntry = svc.intr & ~prevIntr;
  assign nmiEntry  = svc.nmi & ~prevNmi;
  assign fastMode  = (intMode == MODE1) || (intMode == MODE2);
  assign vecMasked = svc.intr && (intMode == MODE2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIntr <= 1'b0;
      prevNmi  <= 1'b0;
    end else begin
      prevIntr <= svc.intr;
      prevNmi  <= svc.nmi;
    end
  end

  // Enable flags: entry edges win over instruction strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (intrEntry) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (nmiEntry) begin
      iff1 <= 1'b0;
    end else if (diEiStrobe) begin
      iff1 <= opField[0];
      iff2 <= opField[0];
    end else if (retnStrobe) begin
      iff1 <= iff2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         intMode <= MODE0;
    else if (imStrobe) intMode <= modeFromField(opField);
  end

  // Opcode substitution
  always_comb begin
    if (svc.halt)                          opcodeOut = NOP_CODE;
    else if (svc.nmi || (svc.intr && fastMode)) opcodeOut = RST_CODE;
    else                                   opcodeOut = fetchByte;
  end

  // Restart target low byte
  always_comb begin
    vectorByte = '0;
    if (svc.nmi)         vectorByte = NMI_VEC;
    else if (!vecMasked) vectorByte[RST_HI:RST_LO] = opcodeOut[RST_HI:RST_LO];
  end

  assign pcHold    = svc.halt | svc.intr | svc.nmi;
  assign extraRead = vecMasked;

  // R6
  nmi_iff_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svc.nmi) |=> (!iff1 && $stable(iff2)));

  // R7
  intr_iff_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svc.intr) |=> (!iff1 && !iff2));

  // R9
  ei_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (diEiStrobe && !svc.intr && !svc.nmi) |=> (iff1 == $past(opField[0]) && iff2 == iff1));

  // R10
  mode2_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (imStrobe && opField == 2'b11) |=> (intMode == MODE2));
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] fetchByte,
  input  logic [1:0]      opField,
  input  logic            opLoad,
  input  logic            boundary,
  input  logic            haltOp,
  input  logic            retnStrobe,
  input  logic            diEiStrobe,
  input  logic            imStrobe,
  input  logic            nmiReq,
  input  logic            intReq,
  output logic [OP_W-1:0] opcodeOut,
  output logic [OP_W-1:0] vectorByte,
  output logic            pcHold,
  output logic            iff1,
  output logic            iff2,
  output logic [1:0]      intMode,
  output logic            inHalt,
  output logic            inIntr,
  output logic            inNmi,
  output logic            extraRead
);
  svc_t svc;

  irq_entry_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opLoad(opLoad), .boundary(boundary),
    .haltOp(haltOp), .nmiReq(nmiReq), .intReq(intReq), .iff1(iff1),
    .opcodeOut(opcodeOut), .svc(svc)
  );

  irq_entry_dp #(.OP_W(OP_W)) u_dp (
    .clk(clk), .rstN(rstN), .svc(svc), .fetchByte(fetchByte),
    .opField(opField), .retnStrobe(retnStrobe), .diEiStrobe(diEiStrobe),
    .imStrobe(imStrobe), .opcodeOut(opcodeOut), .vectorByte(vectorByte),
    .pcHold(pcHold), .iff1(iff1), .iff2(iff2), .intMode(intMode),
    .extraRead(extraRead)
  );

  assign inHalt = svc.halt;
  assign inIntr = svc.intr;
  assign inNmi  = svc.nmi;
endmodule

// File: tb/irq_entry_unit_bench.sv
module irq_entry_unit_bench;
  localparam int CLK_PERIOD = 10;

  localparam int S_OPC = 0, S_VEC = 1, S_HOLD = 2, S_IFF1 = 3, S_IFF2 = 4;
  localparam int S_MODE = 5, S_HALT = 6, S_INTR = 7, S_NMI = 8, S_XRD = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] fetchByte = 8'h00;
  logic [1:0] opField = 2'b00;
  logic opLoad = 0, boundary = 0, haltOp = 0, retnStrobe = 0;
  logic diEiStrobe = 0, imStrobe = 0, nmiReq = 0, intReq = 0;
  logic [7:0] opcodeOut, vectorByte;
  logic pcHold, iff1, iff2, inHalt, inIntr, inNmi, extraRead;
  logic [1:0] intMode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    string req;
    int    sel;
    int    expv;
  } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_unit u_irq_entry_unit (
    .clk(clk), .rstN(rstN), .fetchByte(fetchByte), .opField(opField),
    .opLoad(opLoad), .boundary(boundary), .haltOp(haltOp),
    .retnStrobe(retnStrobe), .diEiStrobe(diEiStrobe), .imStrobe(imStrobe),
    .nmiReq(nmiReq), .intReq(intReq), .opcodeOut(opcodeOut),
    .vectorByte(vectorByte), .pcHold(pcHold), .iff1(iff1), .iff2(iff2),
    .intMode(intMode), .inHalt(inHalt), .inIntr(inIntr), .inNmi(inNmi),
    .extraRead(extraRead)
  );

  function automatic int observe(input int sel);
    case (sel)
      S_OPC:  return int'(opcodeOut);
      S_VEC:  return int'(vectorByte);
      S_HOLD: return int'(pcHold);
      S_IFF1: return int'(iff1);
      S_IFF2: return int'(iff2);
      S_MODE: return int'(intMode);
      S_HALT: return int'(inHalt);
      S_INTR: return int'(inIntr);
      S_NMI:  return int'(inNmi);
      default: return int'(extraRead);
    endcase
  endfunction

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      int got;
      it = sbq.pop_front();
      got = observe(it.sel);
      total++;
      if (got != it.expv) begin
        bad++;
        $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.req, it.sel, got, it.expv);
      end
    end
  end

  // Driver side
  task automatic tick();
    @(posedge clk);
  endtask

  task automatic expect_v(input string req, input int sel, input int v);
    item_t it;
    it.req = req; it.sel = sel; it.expv = v;
    sbq.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
    opLoad = 0; boundary = 0; haltOp = 0; retnStrobe = 0;
    diEiStrobe = 0; imStrobe = 0;
  endtask

  task automatic setMode(input logic [1:0] f);
    opField = f; imStrobe = 1; tick(); settle();
  endtask

  task automatic enableIrq();
    opField = 2'b11; diEiStrobe = 1; tick(); settle();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    fetchByte = 8'hD7;
    tick();
    expect_v("R1 iff1", S_IFF1, 0); expect_v("R1 iff2", S_IFF2, 0);
    expect_v("R1 mode", S_MODE, 0); expect_v("R1 halt", S_HALT, 0);
    expect_v("R1 intr", S_INTR, 0); expect_v("R1 nmi", S_NMI, 0);
    expect_v("R1 pcHold", S_HOLD, 0); expect_v("R1 passthrough", S_OPC, 'hD7);
    expect_v("R4 restart vector", S_VEC, 'h10);
    settle();
    rstN = 1; tick(); settle();

    // R10: mode mapping
    opField = 2'b10; imStrobe = 1; tick(); expect_v("R10 field10", S_MODE, 1); settle();
    opField = 2'b01; imStrobe = 1; tick(); expect_v("R10 field01", S_MODE, 0); settle();
    opField = 2'b11; imStrobe = 1; tick(); expect_v("R10 field11", S_MODE, 2); settle();
    opField = 2'b00; imStrobe = 1; tick(); expect_v("R10 field00", S_MODE, 0); settle();
    setMode(2'b10);

    // R9: enable
    opField = 2'b01; diEiStrobe = 1; tick();
    expect_v("R9 ei iff1", S_IFF1, 1); expect_v("R9 ei iff2", S_IFF2, 1); settle();

    // R7: maskable accept in mode 1
    intReq = 1; boundary = 1; fetchByte = 8'h12; tick();
    expect_v("R7 accept", S_INTR, 1); expect_v("R3 rst opcode", S_OPC, 'hFF);
    expect_v("R4 mode1 vector", S_VEC, 'h38); expect_v("R5 hold intr", S_HOLD, 1);
    expect_v("R11 no extra read", S_XRD, 0); expect_v("R7 iff1 not yet", S_IFF1, 1);
    settle();
    intReq = 0; tick();
    expect_v("R7 iff1 cleared", S_IFF1, 0); expect_v("R7 iff2 cleared", S_IFF2, 0);
    expect_v("R12 intr lasts", S_INTR, 1); settle();
    boundary = 1; tick();
    expect_v("R12 intr ends", S_INTR, 0); expect_v("R1 passthrough", S_OPC, 'h12);
    expect_v("R5 hold off", S_HOLD, 0); settle();

    // R9 disable then R7 rejection
    enableIrq();
    opField = 2'b00; diEiStrobe = 1; tick();
    expect_v("R9 di iff1", S_IFF1, 0); expect_v("R9 di iff2", S_IFF2, 0); settle();
    intReq = 1; boundary = 1; tick();
    expect_v("R7 masked", S_INTR, 0); settle();
    intReq = 0;

    // R6: NMI priority and flag handling
    enableIrq();
    nmiReq = 1; tick(); expect_v("R6 not yet", S_NMI, 0); settle();
    intReq = 1; boundary = 1; tick();
    expect_v("R6 nmi enters", S_NMI, 1); expect_v("R6 int loses", S_INTR, 0);
    expect_v("R3 nmi opcode", S_OPC, 'hFF); expect_v("R4 nmi vector", S_VEC, 'h66);
    expect_v("R5 hold nmi", S_HOLD, 1); settle();
    intReq = 0; tick();
    expect_v("R6 iff1 cleared", S_IFF1, 0); expect_v("R6 iff2 kept", S_IFF2, 1); settle();
    boundary = 1; tick(); expect_v("R6 nmi ends", S_NMI, 0); settle();
    boundary = 1; tick(); expect_v("R6 level no retrigger", S_NMI, 0); settle();
    nmiReq = 0;
    retnStrobe = 1; tick(); expect_v("R9 retn", S_IFF1, 1); settle();

    // R11 / R4: mode 2
    setMode(2'b11);
    intReq = 1; boundary = 1; fetchByte = 8'h34; tick();
    expect_v("R11 extra read", S_XRD, 1); expect_v("R4 masked vector", S_VEC, 0);
    expect_v("R3 mode2 opcode", S_OPC, 'hFF); settle();
    intReq = 0; boundary = 1; tick();
    expect_v("R11 extra read off", S_XRD, 0); settle();

    // R3: mode 0 pass-through
    setMode(2'b00);
    enableIrq();
    intReq = 1; boundary = 1; fetchByte = 8'hE7; tick();
    expect_v("R3 mode0 accept", S_INTR, 1); expect_v("R3 mode0 opcode", S_OPC, 'hE7);
    expect_v("R4 mode0 vector", S_VEC, 'h20); settle();
    intReq = 0; boundary = 1; tick(); settle();

    // R8: block after enable opcode
    enableIrq();
    opLoad = 1; fetchByte = 8'hFB; tick(); settle();
    intReq = 1; boundary = 1; tick(); expect_v("R8 int blocked", S_INTR, 0); settle();
    boundary = 1; tick(); expect_v("R8 int after block", S_INTR, 1); settle();
    intReq = 0; boundary = 1; tick(); settle();

    // R8: block after prefix, NMI waits
    nmiReq = 1; opLoad = 1; fetchByte = 8'hCB; tick(); settle();
    boundary = 1; tick(); expect_v("R8 nmi blocked", S_NMI, 0); settle();
    boundary = 1; tick(); expect_v("R8 nmi after block", S_NMI, 1); settle();
    nmiReq = 0; boundary = 1; tick(); settle();

    // R2 / R12: halt
    haltOp = 1; fetchByte = 8'h77; tick();
    expect_v("R12 halt set", S_HALT, 1); expect_v("R2 nop", S_OPC, 'h00);
    expect_v("R5 hold halt", S_HOLD, 1); settle();
    boundary = 1; tick(); expect_v("R12 halt stays", S_HALT, 1); settle();
    enableIrq();
    setMode(2'b10);
    intReq = 1; boundary = 1; tick();
    expect_v("R12 halt exit", S_HALT, 0); expect_v("R12 intr from halt", S_INTR, 1);
    settle();
    intReq = 0; boundary = 1; tick(); settle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule